// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a free-running supervision timer that counts system clock cycles against a programmable period. Software has to service it before every period runs out by writing an acknowledge command carrying a fixed key. If a period ends without that acknowledge, the block raises a warning interrupt. If the next period also ends without an acknowledge, it asks for a system reset.

The timer has no enable and no stop control. From the moment its internal reset is released it is always counting, and no value written through the register port can halt it. A new period value is taken into use only at the next reload, which is either an acknowledge or an expiry. The period that is already running is never shortened or stretched by a write.

The reset request is a single-cycle pulse that is meant for an external reset network. After the pulse the timer is back in its first stage and a fresh period has begun.

Top module: `wdg_escalate`

## Requirements
- R1: While reset is applied, and after it is released, `irq` and `rst_req` are 0. The external active-low reset `rst_n` clears the block at once. Its release passes through a two-flop synchronizer, so the first counting edge is the third rising clock edge after `rst_n` goes high. After reset the period value is the parameter `DEF_TIMEOUT`.
- R2: With period value T loaded at a reload edge, an expiry occurs on the (T+1)-th rising edge after that reload, provided no valid acknowledge arrives first. The first expiry after an acknowledge sets `irq` to 1 from that edge on.
- R3: `irq` stays at 1 until a valid acknowledge is taken. A valid acknowledge clears `irq` on the following edge and returns the timer to its first stage.
- R4: A second consecutive expiry, with no valid acknowledge after the first one, drives `rst_req` to 1 for exactly one cycle and clears `irq` on the same edge. The timer then returns to its first stage, and the next expiry occurs T+1 edges later.
- R5: A valid acknowledge reloads the counter with the current period value. Acknowledges that arrive at most T edges apart never let `irq` or `rst_req` rise.
- R6: A write with `wr_sel`=0 stores `wr_data` as the period value. The period that is already running is unaffected, and the new value is loaded at the next reload, whether that reload is an acknowledge or an expiry.
- R7: A valid acknowledge is a write with `wr_sel`=1 and `wr_data` equal to the parameter `ACK_KEY`. A write with `wr_sel`=1 and any other data has no effect: `irq` stays as it is and the pending reset request still follows on time.
- R8: The timer cannot be disabled. A period value of 0 makes every edge an expiry, so after an acknowledge `irq` rises on the next edge and `rst_req` pulses on the edge after that.
- R9: A valid acknowledge taken on the same edge on which the counter would expire takes priority. No stage change happens, and a full new period of T+1 edges begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| wr_en | input | 1 | Write strobe for the register port, one write per cycle |
| wr_sel | input | 1 | 0 selects the period value, 1 selects the acknowledge command |
| wr_data | input | CNT_W | Period value, or acknowledge key |
| irq | output | 1 | Warning interrupt: level, set on the first missed deadline |
| rst_req | output | 1 | One-cycle reset request on the second consecutive missed deadline |

## Verification
The bench builds the block with an 8-bit counter, a default period of 20 and the key 0x5A. With these values a complete escalation from a missed deadline to a reset pulse takes about forty cycles, so every stage transition can be repeated many times within a short run. The small counter also lets the bench try period values of 0 and 5 next to the default, which makes the reload-timing rule and the every-edge expiry case easy to observe. A reference model in the bench tracks the count, the stage and the period value on every edge, and directed checks sample the expected edge of each escalation step.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Escalation stage of the watchdog
  typedef enum logic {
    STG_ARMED  = 1'b0,   // no deadline missed yet
    STG_WARNED = 1'b1    // one deadline missed, interrupt raised
  } wdg_stage_e;

  // Register port select values
  localparam logic SEL_PERIOD = 1'b0;
  localparam logic SEL_ACK    = 1'b1;

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
  import wdg_pkg::*;
#(
  parameter int unsigned       CNT_W       = 16,
  parameter int unsigned       DEF_TIMEOUT = 1000,
  parameter logic [CNT_W-1:0]  ACK_KEY     = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] period_q,
  output logic             ack
);

  localparam logic [CNT_W-1:0] PERIOD_RST = CNT_W'(DEF_TIMEOUT);

  logic             period_we;
  logic [CNT_W-1:0] period_d;

  // Decode of the write port
  always_comb begin
    period_we = wr_en && (wr_sel == SEL_PERIOD);
    ack       = wr_en && (wr_sel == SEL_ACK) && (wr_data == ACK_KEY);
    period_d  = period_q;
    if (period_we) period_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         period_q <= PERIOD_RST;
    else if (period_we) period_q <= period_d;
  end

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DEF_TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(DEF_TIMEOUT);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    // acknowledge has priority over an expiry on the same edge
    expire  = at_zero && !ack;
    if (ack || at_zero) cnt_d = period;
    else                cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_RST;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic expire,
  output logic irq,
  output logic rst_req
);

  wdg_stage_e stage_q, stage_d;
  logic       irq_d, req_d;
  logic       upd_en;

  always_comb begin
    stage_d = stage_q;
    irq_d   = irq;
    req_d   = 1'b0;
    upd_en  = ack || expire || rst_req;
    if (ack) begin
      stage_d = STG_ARMED;
      irq_d   = 1'b0;
    end else if (expire) begin
      unique case (stage_q)
        STG_ARMED: begin
          stage_d = STG_WARNED;
          irq_d   = 1'b1;
        end
        STG_WARNED: begin
          stage_d = STG_ARMED;
          irq_d   = 1'b0;
          req_d   = 1'b1;
        end
        default: stage_d = STG_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_ARMED;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else if (upd_en) begin
      stage_q <= stage_d;
      irq     <= irq_d;
      rst_req <= req_d;
    end
  end

endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate #(
  parameter int unsigned       CNT_W       = 16,
  parameter int unsigned       DEF_TIMEOUT = 1000,
  parameter logic [CNT_W-1:0]  ACK_KEY     = 16'hA5C3,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             irq,
  output logic             rst_req
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] period_q;
  logic             ack;
  logic             expire;

  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdg_cfg #(
    .CNT_W       (CNT_W),
    .DEF_TIMEOUT (DEF_TIMEOUT),
    .ACK_KEY     (ACK_KEY)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .period_q (period_q),
    .ack      (ack)
  );

  wdg_count #(
    .CNT_W       (CNT_W),
    .DEF_TIMEOUT (DEF_TIMEOUT)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ack    (ack),
    .period (period_q),
    .expire (expire)
  );

  wdg_stage u_stage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ack     (ack),
    .expire  (expire),
    .irq     (irq),
    .rst_req (rst_req)
  );

endmodule

// File: rtl/wdg_escalate_chk.sv
module wdg_escalate_chk #(
  parameter int unsigned       CNT_W   = 16,
  parameter logic [CNT_W-1:0]  ACK_KEY = '1
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             expire,
  input logic             irq,
  input logic             rst_req
);

  logic key_ok;
  assign key_ok = wr_en && wr_sel && (wr_data == ACK_KEY);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_req |=> !rst_req);

  // R4
  req_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_req |-> ($past(irq) && !irq));

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    key_ok |=> (!irq && !rst_req));

  // R2
  expire_acts_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire |=> (irq || rst_req));

  // R3
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!key_ok && !expire) |=> ($stable(irq) && !rst_req));

  // R9
  ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    key_ok |-> !expire);

endmodule

bind wdg_escalate wdg_escalate_chk #(
  .CNT_W   (CNT_W),
  .ACK_KEY (ACK_KEY)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .expire     (expire),
  .irq        (irq),
  .rst_req    (rst_req)
);

// File: tb/test_wdg_escalate.sv
module test_wdg_escalate;

  localparam int unsigned CNT_W = 8;
  localparam int unsigned T     = 20;
  localparam logic [7:0]  KEY   = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq, rst_req;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  string phase = "R1";

  // reference model state
  int m_cnt = T, m_per = T, m_sr = 0;
  bit m_warn = 0, m_irq = 0, m_req = 0;

  always #5 clk = ~clk;

  wdg_escalate #(
    .CNT_W(CNT_W), .DEF_TIMEOUT(T), .ACK_KEY(KEY), .SYNC_STAGES(2)
  ) i_wdg_escalate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq(irq), .rst_req(rst_req)
  );

  // Behavioural reference: one step per counting edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = T; m_per = T; m_sr = 0; m_warn = 0; m_irq = 0; m_req = 0;
    end else begin
      if (m_sr >= 2) begin
        bit good_ack;
        good_ack = wr_en && wr_sel && (wr_data == KEY);
        m_req = 0;
        if (good_ack) begin
          m_cnt = m_per; m_warn = 0; m_irq = 0;
        end else if (m_cnt == 0) begin
          m_cnt = m_per;
          if (!m_warn) begin m_warn = 1; m_irq = 1; end
          else begin m_warn = 0; m_irq = 0; m_req = 1; end
        end else begin
          m_cnt = m_cnt - 1;
        end
        if (wr_en && !wr_sel) m_per = int'(wr_data);
      end
      if (m_sr < 2) m_sr = m_sr + 1;
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (irq !== m_irq || rst_req !== m_req) begin
        errors++;
        $display("FAIL %s model: irq=%0b rst_req=%0b expected irq=%0b rst_req=%0b",
                 phase, irq, rst_req, m_irq, m_req);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one write cycle: returns at the negedge after the sampling edge
  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL bench timeout: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    phase = "R1";
    cyc(3);
    check("R1 irq in reset", irq, 1'b0);
    check("R1 rst_req in reset", rst_req, 1'b0);
    rst_n = 1'b1;
    cyc(4);
    check("R1 irq after release", irq, 1'b0);
    check("R1 rst_req after release", rst_req, 1'b0);

    // R2: expiry T+1 edges after the acknowledge reload
    phase = "R2";
    wr(1'b1, KEY);
    cyc(T);
    check("R2 no irq after T edges", irq, 1'b0);
    cyc(1);
    check("R2 irq at edge T+1", irq, 1'b1);

    // R3: acknowledge clears the interrupt
    phase = "R3";
    cyc(3);
    check("R3 irq held", irq, 1'b1);
    wr(1'b1, KEY);
    check("R3 irq cleared by ack", irq, 1'b0);

    // R4: second consecutive expiry
    phase = "R4";
    cyc(T + 1);
    check("R4 first stage irq", irq, 1'b1);
    cyc(T);
    check("R4 no request yet", rst_req, 1'b0);
    cyc(1);
    check("R4 rst_req pulse", rst_req, 1'b1);
    check("R4 irq cleared with request", irq, 1'b0);
    cyc(1);
    check("R4 pulse one cycle", rst_req, 1'b0);
    cyc(T - 1);
    check("R4 restart no irq", irq, 1'b0);
    cyc(1);
    check("R4 restart irq after T+1", irq, 1'b1);

    // R7: wrong key ignored while warned
    phase = "R7";
    wr(1'b1, KEY ^ 8'h01);
    check("R7 irq kept after wrong key", irq, 1'b1);
    cyc(T - 1);
    check("R7 no early request", rst_req, 1'b0);
    cyc(1);
    check("R7 request still on time", rst_req, 1'b1);

    // R5: regular service keeps it quiet
    phase = "R5";
    for (int k = 0; k < 10; k++) begin
      wr(1'b1, KEY);
      cyc(T - 1);
      check("R5 serviced no irq", irq, 1'b0);
      check("R5 serviced no request", rst_req, 1'b0);
    end

    // R9: ack on the expiry edge wins
    phase = "R9";
    wr(1'b1, KEY);
    cyc(T);
    wr(1'b1, KEY);
    check("R9 no irq when ack meets expiry", irq, 1'b0);
    cyc(T);
    check("R9 full new period", irq, 1'b0);
    cyc(1);
    check("R9 expiry after new period", irq, 1'b1);

    // R6: new period only at next reload
    phase = "R6";
    wr(1'b1, KEY);
    cyc(3);
    wr(1'b0, 8'd5);
    cyc(T - 4);
    check("R6 running period unchanged", irq, 1'b0);
    cyc(1);
    check("R6 expiry on old period", irq, 1'b1);
    cyc(5);
    check("R6 no request before new period", rst_req, 1'b0);
    cyc(1);
    check("R6 request after new period", rst_req, 1'b1);

    // R8: period 0 expires on every edge
    phase = "R8";
    wr(1'b0, 8'd0);
    wr(1'b1, KEY);
    check("R8 ack clears", irq, 1'b0);
    cyc(1);
    check("R8 irq next edge", irq, 1'b1);
    cyc(1);
    check("R8 request edge after", rst_req, 1'b1);

    // R1: asynchronous reset mid-run
    phase = "R1";
    wr(1'b0, 8'd3);
    cyc(2);
    rst_n = 1'b0;
    cyc(1);
    check("R1 irq cleared by reset", irq, 1'b0);
    check("R1 request cleared by reset", rst_req, 1'b0);
    rst_n = 1'b1;
    // default period again: counting starts at third edge, expiry T+1 later
    cyc(2 + T);
    check("R1 default period restored", irq, 1'b0);
    cyc(1);
    check("R1 first expiry after release", irq, 1'b1);

    cyc(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule